// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block walks a table of shared interrupt lines, one entry per clock, and for each of a parameterised number of processor targets keeps the best interrupt that can be delivered to that target. An entry is a candidate when it is pending, enabled, not active, and the group it resolves to is enabled. The group is derived from a per-line group bit, a per-line modifier bit and a global security-enable input. Each line carries a 64-bit routing word. That word either names one target by four affinity bytes, or asks for delivery to the lowest-numbered target that is flagged as participating.

The block owns the pending and active bits of every line. A one-cycle pulse vector raises pending. An acknowledge command moves a line from pending to active, and a deactivate command clears active. Per-line status is reported as a 2-bit code. Whenever any configuration input or any pending or active bit changes, the scan starts again from the first line. Results are published per target only when a complete, uninterrupted pass has finished.

Top module: `hpi_select`

## Requirements
- R1: After reset every target reports valid low, ID 0, priority 0xFF and group code 0, and every line's status code is 0.
- R2: A line is considered only when it is pending, enabled, not active, and its resolved group has its enable set (group-enable bit 0 = group 0, bit 1 = group 1 non-secure, bit 2 = group 1 secure).
- R3: With security disabled, a group bit of 1 resolves to group 1 non-secure (code 1) and a group bit of 0 resolves to group 0 (code 0); the modifier bit is ignored.
- R4: With security enabled, the pair {modifier, group} resolves as 00 to group 0 (code 0), 01 to group 1 non-secure (code 1), 10 to group 1 secure (code 2), and 11 to group 1 non-secure (code 1).
- R5: Among the candidates for a target, the lowest priority value wins, and on equal priority the lower interrupt ID wins. Line i carries ID FIRST_ID+i.
- R6: With routing bit 31 clear, a line goes to the lowest-numbered target whose 32-bit affinity equals {route[39:32], route[23:16], route[15:8], route[7:0]}.
- R7: With routing bit 31 set, a line goes to the lowest-numbered target whose participation flag is set. If no target participates, the line is not presented.
- R8: A line that matches no target is presented nowhere and keeps its pending state.
- R9: A target with no winning candidate reports valid low and priority 0xFF. A line with priority 0xFF never wins.
- R10: Status code per line is {active, pending}: 0 inactive, 1 pending, 2 active, 3 active and pending. Acknowledge of an ID clears its pending bit and sets its active bit; deactivate clears its active bit.
- R11: Outputs change only at the end of a complete scan pass. Any change of inputs or state restarts the pass, so a new result appears no earlier than one full pass after the last change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_en | input | 1 | Security enabled |
| grp_en | input | 3 | Group enables: [0] group 0, [1] group 1 non-secure, [2] group 1 secure |
| irq_en | input | N_IRQ | Per-line enable |
| irq_grp | input | N_IRQ | Per-line group bit |
| irq_mod | input | N_IRQ | Per-line group modifier bit |
| irq_prio | input | 8*N_IRQ | Per-line priority, line i at [8i+7:8i] |
| irq_route | input | 64*N_IRQ | Per-line routing word, line i at [64i+63:64i] |
| pend_set | input | N_IRQ | One-cycle pulses that raise pending |
| tgt_aff | input | 32*NUM_TGT | Per-target affinity {Aff3,Aff2,Aff1,Aff0} |
| tgt_part | input | NUM_TGT | Per-target participation flag |
| ack_valid | input | 1 | Acknowledge command strobe |
| ack_id | input | IDW | Acknowledged interrupt ID |
| deact_valid | input | 1 | Deactivate command strobe |
| deact_id | input | IDW | Deactivated interrupt ID |
| hp_valid | output | NUM_TGT | Per-target winner present |
| hp_id | output | IDW*NUM_TGT | Per-target winning ID |
| hp_prio | output | 8*NUM_TGT | Per-target winning priority (0xFF when idle) |
| hp_grp | output | 2*NUM_TGT | Per-target winning group code |
| irq_status | output | 2*N_IRQ | Per-line status {active, pending} |

## Verification
The bench builds the block with eight lines starting at ID 32 and three targets. A pass then takes eight cycles, so the test can sample the outputs in the middle of a pass as well as after it has settled. With three targets, one line can be steered to each target by affinity. It also makes the any-participant mode observable as the participation mask moves from the middle target to the last target and then to none. Distinct affinities on the three targets also leave room for a routing word that matches no target at all.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
   localparam int          PRIO_W    = 8;
   localparam logic [7:0]  PRIO_IDLE = 8'hFF;

   typedef enum logic [1:0] {
      GRP_0   = 2'd0,
      GRP_1NS = 2'd1,
      GRP_1S  = 2'd2
   } grp_e;

   function automatic grp_e resolve_grp(input logic sec, input logic m, input logic g);
      grp_e r;
      if (!sec)
         r = g ? GRP_1NS : GRP_0;
      else begin
         case ({m, g})
            2'b00:   r = GRP_0;
            2'b10:   r = GRP_1S;
            default: r = GRP_1NS;
         endcase
      end
      return r;
   endfunction

   function automatic logic grp_on(input grp_e g, input logic [2:0] en);
      logic r;
      case (g)
         GRP_0:   r = en[0];
         GRP_1NS: r = en[1];
         GRP_1S:  r = en[2];
         default: r = 1'b0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/hpi_state.sv
module hpi_state #(
   parameter int N_IRQ    = 32,
   parameter int IDW      = 10,
   parameter int FIRST_ID = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_IRQ-1:0]   pend_set,
   input  logic               ack_valid,
   input  logic [IDW-1:0]     ack_id,
   input  logic               deact_valid,
   input  logic [IDW-1:0]     deact_id,
   output logic [N_IRQ-1:0]   pend,
   output logic [N_IRQ-1:0]   act,
   output logic [2*N_IRQ-1:0] status
);
   logic [N_IRQ-1:0] ack_mask;
   logic [N_IRQ-1:0] deact_mask;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_line
      assign ack_mask[i]   = ack_valid   && (ack_id   == IDW'(FIRST_ID + i));
      assign deact_mask[i] = deact_valid && (deact_id == IDW'(FIRST_ID + i));
      assign status[2*i]   = pend[i];
      assign status[2*i+1] = act[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         act  <= '0;
      end else begin
         pend <= (pend & ~ack_mask) | pend_set;
         act  <= (act & ~deact_mask) | ack_mask;
      end
   end
endmodule

// File: rtl/hpi_route.sv
module hpi_route #(
   parameter int NUM_TGT = 4
) (
   input  logic [63:0]          route,
   input  logic [32*NUM_TGT-1:0] tgt_aff,
   input  logic [NUM_TGT-1:0]   tgt_part,
   output logic [NUM_TGT-1:0]   hit_oh
);
   logic        any_mode;
   logic [31:0] want_aff;
   logic [NUM_TGT-1:0] raw;

   assign any_mode = route[31];
   assign want_aff = {route[39:32], route[23:16], route[15:8], route[7:0]};

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      assign raw[t] = any_mode ? tgt_part[t] : (tgt_aff[32*t +: 32] == want_aff);
   end

   always_comb begin
      logic found;
      found  = 1'b0;
      hit_oh = '0;
      for (int t = 0; t < NUM_TGT; t++) begin
         if (raw[t] && !found) begin
            hit_oh[t] = 1'b1;
            found     = 1'b1;
         end
      end
   end
endmodule

// File: rtl/hpi_scan.sv
module hpi_scan #(
   parameter int N_IRQ    = 32,
   parameter int NUM_TGT  = 4,
   parameter int IDW      = 10,
   parameter int FIRST_ID = 32,
   parameter int IW       = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   restart,
   input  logic                   cand,
   input  logic [7:0]             prio_i,
   input  logic [1:0]             grp_i,
   input  logic [NUM_TGT-1:0]     hit_oh,
   output logic [IW-1:0]          scan_idx,
   output logic [NUM_TGT-1:0]     hp_valid,
   output logic [IDW*NUM_TGT-1:0] hp_id,
   output logic [8*NUM_TGT-1:0]   hp_prio,
   output logic [2*NUM_TGT-1:0]   hp_grp
);
   import hpi_pkg::*;

   localparam logic [IW-1:0] LAST = IW'(N_IRQ - 1);

   logic           last;
   logic [IDW-1:0] cur_id;

   assign last   = (scan_idx == LAST);
   assign cur_id = IDW'(FIRST_ID + int'(scan_idx));

   always_ff @(posedge clk) begin
      if (!rst_n || restart || last)
         scan_idx <= '0;
      else
         scan_idx <= scan_idx + 1'b1;
   end

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      logic           bv, nv, ov;
      logic [7:0]     bp, np, op;
      logic [IDW-1:0] bi, ni, oi;
      logic [1:0]     bg, ng, og;
      logic           take;

      assign take = cand && hit_oh[t] && (prio_i < bp);
      assign nv   = take ? 1'b1   : bv;
      assign np   = take ? prio_i : bp;
      assign ni   = take ? cur_id : bi;
      assign ng   = take ? grp_i  : bg;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bv <= 1'b0; bp <= PRIO_IDLE; bi <= '0; bg <= '0;
            ov <= 1'b0; op <= PRIO_IDLE; oi <= '0; og <= '0;
         end else if (restart || last) begin
            bv <= 1'b0; bp <= PRIO_IDLE; bi <= '0; bg <= '0;
            if (!restart) begin
               ov <= nv; op <= np; oi <= ni; og <= ng;
            end
         end else begin
            bv <= nv; bp <= np; bi <= ni; bg <= ng;
         end
      end

      assign hp_valid[t]          = ov;
      assign hp_prio[8*t +: 8]    = op;
      assign hp_id[IDW*t +: IDW]  = oi;
      assign hp_grp[2*t +: 2]     = og;
   end
endmodule

// File: rtl/hpi_select.sv
module hpi_select #(
   parameter int N_IRQ    = 32,
   parameter int NUM_TGT  = 4,
   parameter int IDW      = 10,
   parameter int FIRST_ID = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sec_en,
   input  logic [2:0]             grp_en,
   input  logic [N_IRQ-1:0]       irq_en,
   input  logic [N_IRQ-1:0]       irq_grp,
   input  logic [N_IRQ-1:0]       irq_mod,
   input  logic [8*N_IRQ-1:0]     irq_prio,
   input  logic [64*N_IRQ-1:0]    irq_route,
   input  logic [N_IRQ-1:0]       pend_set,
   input  logic [32*NUM_TGT-1:0]  tgt_aff,
   input  logic [NUM_TGT-1:0]     tgt_part,
   input  logic                   ack_valid,
   input  logic [IDW-1:0]         ack_id,
   input  logic                   deact_valid,
   input  logic [IDW-1:0]         deact_id,
   output logic [NUM_TGT-1:0]     hp_valid,
   output logic [IDW*NUM_TGT-1:0] hp_id,
   output logic [8*NUM_TGT-1:0]   hp_prio,
   output logic [2*NUM_TGT-1:0]   hp_grp,
   output logic [2*N_IRQ-1:0]     irq_status
);
   import hpi_pkg::*;

   localparam int IW    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
   localparam int CFG_W = 77 * N_IRQ + 4 + 33 * NUM_TGT;

   if (N_IRQ < 1)   begin : g_bad_lines   $error("N_IRQ must be at least 1");   end
   if (NUM_TGT < 1) begin : g_bad_targets $error("NUM_TGT must be at least 1"); end
   if (FIRST_ID + N_IRQ > (1 << IDW)) begin : g_bad_idw
      $error("IDW too narrow for the highest interrupt ID");
   end

   logic [N_IRQ-1:0]   pend, act;
   logic [IW-1:0]      scan_idx;
   logic [CFG_W-1:0]   cfg, cfg_q;
   logic               restart;
   logic [63:0]        cur_route;
   logic [7:0]         cur_prio;
   grp_e               cur_grp;
   logic               cand;
   logic [NUM_TGT-1:0] hit_oh;

   hpi_state #(.N_IRQ(N_IRQ), .IDW(IDW), .FIRST_ID(FIRST_ID)) u_state (
      .clk(clk), .rst_n(rst_n), .pend_set(pend_set),
      .ack_valid(ack_valid), .ack_id(ack_id),
      .deact_valid(deact_valid), .deact_id(deact_id),
      .pend(pend), .act(act), .status(irq_status)
   );

   assign cfg = {irq_en, irq_grp, irq_mod, irq_prio, irq_route, pend, act,
                 sec_en, grp_en, tgt_aff, tgt_part};

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg;
   end

   assign restart   = (cfg != cfg_q);
   assign cur_route = irq_route[64*int'(scan_idx) +: 64];
   assign cur_prio  = irq_prio[8*int'(scan_idx) +: 8];
   assign cur_grp   = resolve_grp(sec_en, irq_mod[scan_idx], irq_grp[scan_idx]);
   assign cand      = pend[scan_idx] && irq_en[scan_idx] && !act[scan_idx]
                      && grp_on(cur_grp, grp_en);

   hpi_route #(.NUM_TGT(NUM_TGT)) u_route (
      .route(cur_route), .tgt_aff(tgt_aff), .tgt_part(tgt_part), .hit_oh(hit_oh)
   );

   hpi_scan #(.N_IRQ(N_IRQ), .NUM_TGT(NUM_TGT), .IDW(IDW), .FIRST_ID(FIRST_ID), .IW(IW)) u_scan (
      .clk(clk), .rst_n(rst_n), .restart(restart), .cand(cand),
      .prio_i(cur_prio), .grp_i(cur_grp), .hit_oh(hit_oh),
      .scan_idx(scan_idx), .hp_valid(hp_valid), .hp_id(hp_id),
      .hp_prio(hp_prio), .hp_grp(hp_grp)
   );
endmodule

// File: rtl/hpi_select_chk.sv
module hpi_select_chk #(
   parameter int N_IRQ    = 32,
   parameter int NUM_TGT  = 4,
   parameter int IDW      = 10,
   parameter int FIRST_ID = 32,
   parameter int IW       = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_TGT-1:0]     hp_valid,
   input logic [IDW*NUM_TGT-1:0] hp_id,
   input logic [8*NUM_TGT-1:0]   hp_prio,
   input logic [2*N_IRQ-1:0]     irq_status,
   input logic                   ack_valid,
   input logic [IDW-1:0]         ack_id,
   input logic                   deact_valid,
   input logic [IDW-1:0]         deact_id,
   input logic [IW-1:0]          scan_idx,
   input logic                   restart
);
   logic q_ack, q_deact, q_pub;
   int   q_aidx, q_didx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_ack <= 1'b0; q_deact <= 1'b0; q_pub <= 1'b0;
         q_aidx <= 0; q_didx <= 0;
      end else begin
         q_ack   <= ack_valid && int'(ack_id) >= FIRST_ID && int'(ack_id) < FIRST_ID + N_IRQ;
         q_deact <= deact_valid && int'(deact_id) >= FIRST_ID && int'(deact_id) < FIRST_ID + N_IRQ
                    && !(ack_valid && ack_id == deact_id);
         q_aidx  <= int'(ack_id) - FIRST_ID;
         q_didx  <= int'(deact_id) - FIRST_ID;
         q_pub   <= (int'(scan_idx) == N_IRQ - 1) && !restart;
      end
   end

   a_r10_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
      q_ack |-> irq_status[2*q_aidx+1]);

   a_r10_deact_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
      q_deact |-> !irq_status[2*q_didx+1]);

   a_r11_hold_mid_scan: assert property (@(posedge clk) disable iff (!rst_n)
      !q_pub |-> ($stable(hp_valid) && $stable(hp_prio) && $stable(hp_id)));

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      a_r9_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
         !hp_valid[t] |-> (hp_prio[8*t +: 8] == 8'hFF));
      a_r9_valid_prio: assert property (@(posedge clk) disable iff (!rst_n)
         hp_valid[t] |-> (hp_prio[8*t +: 8] != 8'hFF));
   end
endmodule

bind hpi_select hpi_select_chk #(
   .N_IRQ(N_IRQ), .NUM_TGT(NUM_TGT), .IDW(IDW), .FIRST_ID(FIRST_ID), .IW(IW)
) i_chk (
   .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio),
   .irq_status(irq_status), .ack_valid(ack_valid), .ack_id(ack_id),
   .deact_valid(deact_valid), .deact_id(deact_id),
   .scan_idx(scan_idx), .restart(restart)
);

// File: tb/test_hpi_select.sv
module test_hpi_select;
   localparam int N  = 8;
   localparam int T  = 3;
   localparam int IDW = 10;
   localparam int FID = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_en = 1'b0;
   logic [2:0] grp_en = '0;
   logic [N-1:0] irq_en = '0, irq_grp = '0, irq_mod = '0, pend_set = '0;
   logic [8*N-1:0] irq_prio = {N{8'hFF}};
   logic [64*N-1:0] irq_route = '0;
   logic [32*T-1:0] tgt_aff = {32'h01020304, 32'h00000001, 32'h00000000};
   logic [T-1:0] tgt_part = 3'b110;
   logic ack_valid = 1'b0, deact_valid = 1'b0;
   logic [IDW-1:0] ack_id = '0, deact_id = '0;
   logic [T-1:0] hp_valid;
   logic [IDW*T-1:0] hp_id;
   logic [8*T-1:0] hp_prio;
   logic [2*T-1:0] hp_grp;
   logic [2*N-1:0] irq_status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct { int tgt; bit v; int id; int prio; int grp; string req; } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   hpi_select #(.N_IRQ(N), .NUM_TGT(T), .IDW(IDW), .FIRST_ID(FID)) i_hpi_select (
      .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .grp_en(grp_en),
      .irq_en(irq_en), .irq_grp(irq_grp), .irq_mod(irq_mod),
      .irq_prio(irq_prio), .irq_route(irq_route), .pend_set(pend_set),
      .tgt_aff(tgt_aff), .tgt_part(tgt_part),
      .ack_valid(ack_valid), .ack_id(ack_id),
      .deact_valid(deact_valid), .deact_id(deact_id),
      .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio), .hp_grp(hp_grp),
      .irq_status(irq_status)
   );

   task automatic settle();
      repeat (3*N + 4) @(negedge clk);
   endtask

   task automatic expect_tgt(int t, bit v, int id, int p, int g, string req);
      exp_t e;
      e.tgt = t; e.v = v; e.id = id; e.prio = p; e.grp = g; e.req = req;
      sb.push_back(e);
   endtask

   task automatic expect_idle(int t, string req);
      expect_tgt(t, 1'b0, 0, 8'hFF, 0, req);
   endtask

   // monitor: pops expected items and compares them with the current outputs
   task automatic drain();
      while (sb.size() > 0) begin
         exp_t e;
         int av, ap;
         e = sb.pop_front();
         av = hp_valid[e.tgt];
         ap = hp_prio[8*e.tgt +: 8];
         checks++;
         if (av != e.v || ap != e.prio ||
             (e.v && (int'(hp_id[IDW*e.tgt +: IDW]) != e.id || int'(hp_grp[2*e.tgt +: 2]) != e.grp))) begin
            errors++;
            $display("FAIL %s tgt%0d: got v=%0d id=%0d prio=%02h grp=%0d, expected v=%0d id=%0d prio=%02h grp=%0d",
                     e.req, e.tgt, av, hp_id[IDW*e.tgt +: IDW], ap, hp_grp[2*e.tgt +: 2],
                     e.v, e.id, e.prio, e.grp);
         end
      end
   endtask

   task automatic check_status(int i, int exp, string req);
      checks++;
      if (int'(irq_status[2*i +: 2]) != exp) begin
         errors++;
         $display("FAIL %s status line %0d: got %0d expected %0d", req, i, irq_status[2*i +: 2], exp);
      end
   endtask

   task automatic set_irq(int i, bit e, bit g, bit m, logic [7:0] p, logic [63:0] r);
      @(negedge clk);
      irq_en[i] = e; irq_grp[i] = g; irq_mod[i] = m;
      irq_prio[8*i +: 8] = p; irq_route[64*i +: 64] = r;
   endtask

   task automatic pulse_pend(int i);
      @(negedge clk); pend_set[i] = 1'b1;
      @(negedge clk); pend_set = '0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int t = 0; t < T; t++) expect_idle(t, "R1");
      drain();
      for (int i = 0; i < N; i++) check_status(i, 0, "R1");

      // R2 basic candidate on target 0
      set_irq(0, 1, 1, 0, 8'h40, 64'h0);
      @(negedge clk); grp_en = 3'b010;
      pulse_pend(0);
      settle();
      expect_tgt(0, 1, 32, 8'h40, 1, "R2");
      expect_idle(1, "R2"); expect_idle(2, "R2");
      drain();
      check_status(0, 1, "R10");
      irq_en[0] = 1'b0; settle();
      expect_idle(0, "R2 disabled"); drain();
      irq_en[0] = 1'b1; grp_en = 3'b001; settle();
      expect_idle(0, "R2 group off"); drain();
      grp_en = 3'b010;

      // R5 tie and priority
      set_irq(1, 1, 1, 0, 8'h40, 64'h0);
      pulse_pend(1);
      settle();
      expect_tgt(0, 1, 32, 8'h40, 1, "R5 tie"); drain();
      irq_prio[8 +: 8] = 8'h20; settle();
      expect_tgt(0, 1, 33, 8'h20, 1, "R5 lower"); drain();

      // R10 acknowledge and deactivate
      @(negedge clk); ack_valid = 1'b1; ack_id = 10'd33;
      @(negedge clk); ack_valid = 1'b0;
      settle();
      check_status(1, 2, "R10 ack");
      expect_tgt(0, 1, 32, 8'h40, 1, "R2 active"); drain();
      @(negedge clk); deact_valid = 1'b1; deact_id = 10'd33;
      @(negedge clk); deact_valid = 1'b0;
      settle();
      check_status(1, 0, "R10 deact");
      expect_tgt(0, 1, 32, 8'h40, 1, "R10"); drain();

      // R6 affinity routing
      set_irq(2, 1, 1, 0, 8'h10, 64'h0000_0001_0002_0304);
      pulse_pend(2);
      set_irq(3, 1, 1, 0, 8'h30, 64'h1);
      pulse_pend(3);
      settle();
      expect_tgt(2, 1, 34, 8'h10, 1, "R6");
      expect_tgt(1, 1, 35, 8'h30, 1, "R6");
      expect_tgt(0, 1, 32, 8'h40, 1, "R6"); drain();

      // R7 any-participant routing
      set_irq(4, 1, 1, 0, 8'h05, 64'h8000_0000);
      pulse_pend(4);
      settle();
      expect_tgt(1, 1, 36, 8'h05, 1, "R7 first part"); drain();
      tgt_part = 3'b100; settle();
      expect_tgt(2, 1, 36, 8'h05, 1, "R7 moved");
      expect_tgt(1, 1, 35, 8'h30, 1, "R7 moved"); drain();
      tgt_part = 3'b000; settle();
      expect_tgt(2, 1, 34, 8'h10, 1, "R7 none"); drain();
      check_status(4, 1, "R8 kept pending");

      // R8 no matching target
      set_irq(5, 1, 1, 0, 8'h01, 64'h9);
      pulse_pend(5);
      settle();
      expect_tgt(0, 1, 32, 8'h40, 1, "R8");
      expect_tgt(1, 1, 35, 8'h30, 1, "R8"); drain();
      check_status(5, 1, "R8");

      // R9 priority 0xFF never wins
      set_irq(6, 1, 1, 0, 8'hFF, 64'h1);
      pulse_pend(6);
      irq_en[3] = 1'b0;
      settle();
      expect_idle(1, "R9"); drain();

      // R11 outputs hold mid-scan
      @(negedge clk); irq_prio[0 +: 8] = 8'h38;
      @(negedge clk); @(negedge clk);
      expect_tgt(0, 1, 32, 8'h40, 1, "R11 mid"); drain();
      settle();
      expect_tgt(0, 1, 32, 8'h38, 1, "R11 after"); drain();

      // R4 / R3 group resolution
      set_irq(7, 1, 0, 1, 8'h02, 64'h0);
      pulse_pend(7);
      sec_en = 1'b1; grp_en = 3'b110; settle();
      expect_tgt(0, 1, 39, 8'h02, 2, "R4 g1s"); drain();
      grp_en = 3'b010; settle();
      expect_tgt(0, 1, 32, 8'h38, 1, "R4 g1s off"); drain();
      sec_en = 1'b0; grp_en = 3'b011; settle();
      expect_tgt(0, 1, 39, 8'h02, 0, "R3 g0"); drain();
      sec_en = 1'b1; irq_grp[7] = 1'b1; grp_en = 3'b010; settle();
      expect_tgt(0, 1, 39, 8'h02, 1, "R4 mod11"); drain();

      done = 1'b1;
      finish_run();
   end
endmodule